// File: doc/BRIEF.md
# Data Bus Direction-Turn Gap Enforcer

This block sits between a queue of memory transfer requests and the shared data bus. Each request arrives on a valid/ready stream and is tagged as a read or a write. The block remembers the direction of the most recent transfer. When a request would reverse the bus direction, the block holds off the stream for a number of idle cycles. The idle length depends on which way the bus turns: one count applies when a read is followed by a write, and a separate count applies when a write is followed by a read. Requests in the same direction as the last transfer pass at full rate, one per cycle.

Both idle counts sit in run-time loadable registers, and each resets to its typical value. Every accepted request produces a one-cycle bus grant strobe that carries the request's direction. A free-running window counter measures how well the bus is used. At the close of each fixed-length window it latches how many cycles carried a transfer and how many did not, and it pulses a done strobe.

Top module: `bus_turnaround_gate`

## Requirements
- R1: After reset the bus direction is read, the read-to-write idle count is 6, the write-to-read idle count is 15, `grant` and `win_done` are low, and `win_busy` and `win_idle` are zero.
- R2: A request in the same direction as the last accepted transfer is accepted in the cycle it is presented (no idle cycles), so back-to-back same-direction requests are accepted once per cycle.
- R3: A write request that follows read traffic sees exactly `rd2wr` cycles with `req_ready` low before it is accepted (6 with the reset value).
- R4: A read request that follows write traffic sees exactly `wr2rd` cycles with `req_ready` low before it is accepted (15 with the reset value).
- R5: While a turn gap is running, `req_ready` stays low and no grant is produced from that stall.
- R6: Because the direction resets to read, the first read after reset needs no gap, and the first write after reset needs the read-to-write gap.
- R7: A handshake (`req_valid` and `req_ready` both high at a clock edge) raises `grant` for exactly the following cycle. In that cycle `grant_is_wr` equals the request's `req_is_wr` (1 = write, 0 = read).
- R8: A cycle with `cfg_load` high loads `cfg_rd2wr_gap` and `cfg_wr2rd_gap` into the two idle-count registers, and later turns use the new counts. A count of 0 lets a turn pass with no idle cycles.
- R9: Every WINDOW (100) clock cycles after reset, `win_done` pulses for one cycle. `win_busy` then holds the number of handshakes in that window, and both totals stay unchanged until the next pulse. With continuous traffic and one turn of each kind, the totals are 79 busy and 21 idle.
- R10: At every `win_done` pulse, `win_busy + win_idle` equals WINDOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_is_wr | input | 1 | Request direction, 1 = write, 0 = read |
| req_ready | output | 1 | Request may be accepted this cycle |
| cfg_load | input | 1 | Load both idle counts |
| cfg_rd2wr_gap | input | GAP_W (5) | New read-to-write idle count |
| cfg_wr2rd_gap | input | GAP_W (5) | New write-to-read idle count |
| grant | output | 1 | Bus grant strobe, one cycle per accepted request |
| grant_is_wr | output | 1 | Direction of the granted transfer |
| win_done | output | 1 | Window totals updated this cycle |
| win_busy | output | CNT_W (7) | Transfer cycles in the last window |
| win_idle | output | CNT_W (7) | Idle cycles in the last window |

## Verification
The hardest state to reach is one measurement window that contains exactly one turn of each kind under otherwise unbroken traffic. Only in that window can the 79/21 split be checked as an absolute figure. The stimulus releases reset and starts issuing reads on the very next edge, so window zero and the traffic begin together. It then sends 30 reads, 30 writes and reads until the window closes. Both gaps therefore fall well inside the first 100 cycles. Zero-length gaps, and a second reset that restores the default counts, are reached by loading the registers and then by asserting reset partway through the run.

// File: rtl/tat_pkg.sv
package tat_pkg;
    localparam logic DIR_RD = 1'b0;
    localparam logic DIR_WR = 1'b1;
endpackage

// File: rtl/tat_gap_ctrl.sv
module tat_gap_ctrl
    import tat_pkg::*;
#(
    parameter int GAP_W     = 5,
    parameter int DEF_RD2WR = 6,
    parameter int DEF_WR2RD = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_is_wr,
    input  logic             cfg_load,
    input  logic [GAP_W-1:0] cfg_rd2wr,
    input  logic [GAP_W-1:0] cfg_wr2rd,
    output logic             req_ready,
    output logic             hs,
    output logic [GAP_W-1:0] rd2wr_q,
    output logic [GAP_W-1:0] wr2rd_q
);
    typedef struct packed {
        logic             dir_wr;
        logic [GAP_W-1:0] cnt;
        logic [GAP_W-1:0] rd2wr;
        logic [GAP_W-1:0] wr2rd;
    } gap_st_t;

    gap_st_t st_q, st_d;
    logic             turn;
    logic [GAP_W-1:0] turn_len;
    logic             ready_c;

    always_comb begin
        st_d     = st_q;
        ready_c  = 1'b1;
        turn     = req_valid && (req_is_wr != st_q.dir_wr);
        turn_len = req_is_wr ? st_q.rd2wr : st_q.wr2rd;
        if (st_q.cnt != '0) begin
            // gap still running: hold the stream
            ready_c  = 1'b0;
            st_d.cnt = st_q.cnt - GAP_W'(1);
        end else if (turn) begin
            // commit the new direction now; this cycle is the first idle one
            st_d.dir_wr = req_is_wr;
            if (turn_len != '0) begin
                ready_c  = 1'b0;
                st_d.cnt = turn_len - GAP_W'(1);
            end
        end
        if (cfg_load) begin
            st_d.rd2wr = cfg_rd2wr;
            st_d.wr2rd = cfg_wr2rd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.dir_wr <= DIR_RD;
            st_q.cnt    <= '0;
            st_q.rd2wr  <= GAP_W'(DEF_RD2WR);
            st_q.wr2rd  <= GAP_W'(DEF_WR2RD);
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = ready_c;
    assign hs        = req_valid && ready_c;
    assign rd2wr_q   = st_q.rd2wr;
    assign wr2rd_q   = st_q.wr2rd;
endmodule

// File: rtl/tat_grant_stage.sv
module tat_grant_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic hs,
    input  logic hs_is_wr,
    output logic grant,
    output logic grant_is_wr
);
    typedef struct packed {
        logic vld;
        logic wr;
    } gnt_st_t;

    gnt_st_t st_q, st_d;

    always_comb begin
        st_d.vld = hs;
        st_d.wr  = hs ? hs_is_wr : st_q.wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant       = st_q.vld;
    assign grant_is_wr = st_q.wr;
endmodule

// File: rtl/tat_util_win.sv
module tat_util_win #(
    parameter int WINDOW = 100,
    parameter int CNT_W  = $clog2(WINDOW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_in,
    output logic             done,
    output logic [CNT_W-1:0] busy_tot,
    output logic [CNT_W-1:0] idle_tot
);
    localparam int WCNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;

    typedef struct packed {
        logic [WCNT_W-1:0] wcnt;
        logic [CNT_W-1:0]  acc;
        logic [CNT_W-1:0]  busy;
        logic [CNT_W-1:0]  idle;
        logic              done;
    } win_st_t;

    win_st_t st_q, st_d;
    logic [CNT_W-1:0] sum_c;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        sum_c     = st_q.acc + CNT_W'(busy_in);
        if (st_q.wcnt == WCNT_W'(WINDOW - 1)) begin
            st_d.busy = sum_c;
            st_d.idle = CNT_W'(WINDOW) - sum_c;
            st_d.done = 1'b1;
            st_d.acc  = '0;
            st_d.wcnt = '0;
        end else begin
            st_d.acc  = sum_c;
            st_d.wcnt = st_q.wcnt + WCNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done     = st_q.done;
    assign busy_tot = st_q.busy;
    assign idle_tot = st_q.idle;
endmodule

// File: rtl/bus_turnaround_gate.sv
module bus_turnaround_gate #(
    parameter int GAP_W     = 5,
    parameter int DEF_RD2WR = 6,
    parameter int DEF_WR2RD = 15,
    parameter int WINDOW    = 100,
    localparam int CNT_W    = $clog2(WINDOW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_is_wr,
    output logic             req_ready,
    input  logic             cfg_load,
    input  logic [GAP_W-1:0] cfg_rd2wr_gap,
    input  logic [GAP_W-1:0] cfg_wr2rd_gap,
    output logic             grant,
    output logic             grant_is_wr,
    output logic             win_done,
    output logic [CNT_W-1:0] win_busy,
    output logic [CNT_W-1:0] win_idle
);
    logic             hs;
    logic [GAP_W-1:0] gap_rd2wr_q;
    logic [GAP_W-1:0] gap_wr2rd_q;

    tat_gap_ctrl #(
        .GAP_W    (GAP_W),
        .DEF_RD2WR(DEF_RD2WR),
        .DEF_WR2RD(DEF_WR2RD)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_is_wr(req_is_wr),
        .cfg_load (cfg_load),
        .cfg_rd2wr(cfg_rd2wr_gap),
        .cfg_wr2rd(cfg_wr2rd_gap),
        .req_ready(req_ready),
        .hs       (hs),
        .rd2wr_q  (gap_rd2wr_q),
        .wr2rd_q  (gap_wr2rd_q)
    );

    tat_grant_stage u_gnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs         (hs),
        .hs_is_wr   (req_is_wr),
        .grant      (grant),
        .grant_is_wr(grant_is_wr)
    );

    tat_util_win #(
        .WINDOW(WINDOW),
        .CNT_W (CNT_W)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_in (hs),
        .done    (win_done),
        .busy_tot(win_busy),
        .idle_tot(win_idle)
    );
endmodule

// File: rtl/tat_checker.sv
module tat_checker #(
    parameter int GAP_W  = 5,
    parameter int WINDOW = 100,
    parameter int CNT_W  = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_is_wr,
    input logic             req_ready,
    input logic             grant,
    input logic             grant_is_wr,
    input logic             win_done,
    input logic [CNT_W-1:0] win_busy,
    input logic [CNT_W-1:0] win_idle,
    input logic [GAP_W-1:0] rd2wr,
    input logic [GAP_W-1:0] wr2rd
);
    p_grant_from_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> $past(req_valid && req_ready));

    p_grant_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (grant_is_wr == $past(req_is_wr)));

    p_same_dir_flows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && req_valid && (req_is_wr == grant_is_wr)) |-> req_ready);

    p_rd_to_wr_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !grant_is_wr && req_valid && req_is_wr && (rd2wr != '0)) |-> !req_ready);

    p_wr_to_rd_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && grant_is_wr && req_valid && !req_is_wr && (wr2rd != '0)) |-> !req_ready);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done);

    p_totals_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |-> ($stable(win_busy) && $stable(win_idle)));

    p_window_sum_r10: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> ((32'(win_busy) + 32'(win_idle)) == WINDOW));
endmodule

bind bus_turnaround_gate tat_checker #(
    .GAP_W (GAP_W),
    .WINDOW(WINDOW),
    .CNT_W (CNT_W)
) u_tat_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_is_wr  (req_is_wr),
    .req_ready  (req_ready),
    .grant      (grant),
    .grant_is_wr(grant_is_wr),
    .win_done   (win_done),
    .win_busy   (win_busy),
    .win_idle   (win_idle),
    .rd2wr      (gap_rd2wr_q),
    .wr2rd      (gap_wr2rd_q)
);

// File: tb/bus_turnaround_gate_bench.sv
`timescale 1ns/1ps
module bus_turnaround_gate_bench;
    localparam int GAP_W  = 5;
    localparam int WINDOW = 100;
    localparam int CNT_W  = $clog2(WINDOW + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_is_wr = 1'b0;
    logic             req_ready;
    logic             cfg_load = 1'b0;
    logic [GAP_W-1:0] cfg_rd2wr_gap = '0;
    logic [GAP_W-1:0] cfg_wr2rd_gap = '0;
    logic             grant;
    logic             grant_is_wr;
    logic             win_done;
    logic [CNT_W-1:0] win_busy;
    logic [CNT_W-1:0] win_idle;

    int n_vec  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bus_turnaround_gate u_bus_turnaround_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_is_wr    (req_is_wr),
        .req_ready    (req_ready),
        .cfg_load     (cfg_load),
        .cfg_rd2wr_gap(cfg_rd2wr_gap),
        .cfg_wr2rd_gap(cfg_wr2rd_gap),
        .grant        (grant),
        .grant_is_wr  (grant_is_wr),
        .win_done     (win_done),
        .win_busy     (win_busy),
        .win_idle     (win_idle)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural reference, stepped once per cycle at the falling edge
    int m_dir, m_gap, m_rw, m_wr, m_grant, m_gwr;
    int m_wcnt, m_acc, m_busy, m_idle, m_done;

    task automatic model_reset();
        m_dir = 0; m_gap = 0; m_rw = 6; m_wr = 15; m_grant = 0; m_gwr = 0;
        m_wcnt = 0; m_acc = 0; m_busy = 0; m_idle = 0; m_done = 0;
    endtask

    initial model_reset();

    always @(negedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int need, exp_rdy, hs;
            need = req_is_wr ? m_rw : m_wr;
            if (m_gap > 0) exp_rdy = 0;
            else if (req_valid && (int'(req_is_wr) != m_dir) && need > 0) exp_rdy = 0;
            else exp_rdy = 1;
            chk(int'(req_ready) == exp_rdy, "R5 req_ready", int'(req_ready), exp_rdy);
            chk(int'(grant) == m_grant, "R7 grant", int'(grant), m_grant);
            if (m_grant == 1)
                chk(int'(grant_is_wr) == m_gwr, "R7 grant_is_wr", int'(grant_is_wr), m_gwr);
            chk(int'(win_done) == m_done, "R9 win_done", int'(win_done), m_done);
            chk(int'(win_busy) == m_busy, "R9 win_busy", int'(win_busy), m_busy);
            chk(int'(win_idle) == m_idle, "R10 win_idle", int'(win_idle), m_idle);
            // advance
            hs = (req_valid && exp_rdy == 1) ? 1 : 0;
            if (m_gap > 0) m_gap--;
            else if (req_valid && (int'(req_is_wr) != m_dir)) begin
                m_dir = int'(req_is_wr);
                if (need > 0) m_gap = need - 1;
            end
            if (cfg_load) begin m_rw = int'(cfg_rd2wr_gap); m_wr = int'(cfg_wr2rd_gap); end
            m_grant = hs;
            if (hs == 1) m_gwr = int'(req_is_wr);
            m_done = 0;
            if (m_wcnt == WINDOW - 1) begin
                m_busy = m_acc + hs; m_idle = WINDOW - m_busy; m_done = 1;
                m_acc = 0; m_wcnt = 0;
            end else begin
                m_acc += hs; m_wcnt++;
            end
        end
    end

    // present one request and wait for it to be taken; returns stall cycles
    task automatic send(input logic wr, output int stalls);
        bit taken;
        req_valid = 1'b1;
        req_is_wr = wr;
        stalls = 0;
        taken = 0;
        while (!taken) begin
            @(negedge clk);
            if (req_ready) begin
                @(posedge clk); #1;
                taken = 1;
            end else begin
                stalls++;
            end
        end
    endtask

    task automatic idle_cycles(input int n);
        req_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        int s, tot;
        bit seen;
        do_reset();
        // R1: reset state
        chk(req_ready === 1'b1, "R1 ready idle", int'(req_ready), 1);
        chk(grant === 1'b0, "R1 grant", int'(grant), 0);
        chk(win_done === 1'b0, "R1 win_done", int'(win_done), 0);
        chk(win_busy == 0 && win_idle == 0, "R1 totals", int'(win_busy) + int'(win_idle), 0);

        // window 0: 30 reads, 30 writes, reads to the end
        send(1'b0, s);
        chk(s == 0, "R6 first read no gap", s, 0);
        tot = 0;
        for (int i = 1; i < 30; i++) begin send(1'b0, s); tot += s; end
        chk(tot == 0, "R2 back-to-back reads", tot, 0);
        send(1'b1, s);
        chk(s == 6, "R3 read-to-write gap", s, 6);
        chk(grant === 1'b1 && grant_is_wr === 1'b1, "R7 write grant", int'(grant_is_wr), 1);
        tot = 0;
        for (int i = 1; i < 30; i++) begin send(1'b1, s); tot += s; end
        chk(tot == 0, "R2 back-to-back writes", tot, 0);
        send(1'b0, s);
        chk(s == 15, "R4 write-to-read gap", s, 15);
        chk(grant === 1'b1 && grant_is_wr === 1'b0, "R7 read grant", int'(grant_is_wr), 0);
        seen = 0;
        for (int i = 0; i < 60 && !seen; i++) begin
            send(1'b0, s);
            if (win_done) seen = 1;
        end
        chk(seen, "R9 window pulse", int'(seen), 1);
        chk(win_busy == 79, "R9 busy total", int'(win_busy), 79);
        chk(win_idle == 21, "R10 idle total", int'(win_idle), 21);

        // R8: reprogram gaps
        idle_cycles(2);
        cfg_rd2wr_gap = 5'd0;
        cfg_wr2rd_gap = 5'd3;
        cfg_load = 1'b1;
        @(posedge clk); #1;
        cfg_load = 1'b0;
        send(1'b1, s);
        chk(s == 0, "R8 zero read-to-write gap", s, 0);
        send(1'b0, s);
        chk(s == 3, "R8 loaded write-to-read gap", s, 3);
        idle_cycles(3);

        // second reset restores defaults; first write needs the gap
        do_reset();
        send(1'b1, s);
        chk(s == 6, "R6 first write after reset", s, 6);
        send(1'b1, s);
        chk(s == 0, "R2 write after write", s, 0);
        send(1'b0, s);
        chk(s == 15, "R1 default write-to-read restored", s, 15);

        // mixed traffic with bubbles, checked cycle by cycle by the model
        for (int i = 0; i < 400; i++) begin
            send(logic'((i / 7) % 2), s);
            if (i % 11 == 0) idle_cycles(2);
        end
        idle_cycles(WINDOW + 5);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule